// File: doc/BRIEF.md
# Palette Vector Quantizer

This block reduces 5:5:5 RGB pixels to 4-bit indices into a 16-colour palette that software loads at run time. Each incoming pixel is compared against every palette colour in turn. The colour with the smallest squared Euclidean distance is selected, and its index is the pixel's code. Two consecutive pixel codes are packed into one output byte. A 16x16 macroblock of pixels therefore becomes 128 bytes, which is 16 rows of 8 bytes.

The palette is written as four 64-bit words on consecutive load strobes, four 16-bit entries per word. Pixels enter on a valid/ready stream in raster order, and each pixel occupies the search engine for 16 cycles. Packed bytes leave as single-cycle pulses. A separate flag marks the final byte of each macroblock.

Top module: `palette_quantizer`

## Requirements
- R1: After reset, `pix_ready` is 1, `out_valid` and `out_last` are 0, all palette entries are zero and the next load word goes to entries 0..3. With that zero palette, every pixel codes to index 0.
- R2: Each `tbl_wr_en` cycle stores one 64-bit word. Load number n (counted modulo 4 since reset) fills entries 4n..4n+3, and entry 4n+j comes from bits 16j+15:16j. Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Bit 15 is ignored.
- R3: A pixel on `pix_data` uses the same field layout: red in 4:0, green in 9:5 and blue in 14:10.
- R4: The code of a pixel is the palette index k that minimises (dr)^2 + (dg)^2 + (db)^2, where each d is the difference between the pixel and entry k in that channel.
- R5: When several entries share the minimum distance, the lowest index is chosen.
- R6: Pixels pair up in arrival order. In each output byte, bits 3:0 hold the first (even-column) pixel's code and bits 7:4 hold the second (odd-column) pixel's code.
- R7: `out_valid` is a single-cycle pulse, one per pixel pair. It rises in the cycle after the 17th rising edge that follows the edge accepting the pair's second pixel.
- R8: `out_last` is high together with `out_valid` on the 128th byte of each macroblock and low on all other bytes. The count then starts over.
- R9: A pixel is accepted on an edge where `pix_valid` and `pix_ready` are both 1. `pix_ready` then stays 0 for 16 cycles, and `pix_valid` is ignored while `pix_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Load strobe for one palette word |
| tbl_wr_data | input | 64 | Four packed 16-bit palette entries |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_data | input | 15 | Pixel, 5:5:5 RGB |
| out_valid | output | 1 | Packed byte valid (one-cycle pulse) |
| out_byte | output | 8 | Two packed palette indices |
| out_last | output | 1 | Last byte of a macroblock |

## Verification
The tie rule is the hardest behaviour to expose from the ports. A tie changes the result only when two entries sit at exactly the same distance and a later entry would otherwise displace an earlier one. The stimulus creates ties on purpose in three ways: odd grey levels placed midway between two even grey palette colours, a palette whose entries are all identical, and a palette holding two equal entries at indices 6 and 11 among far-away ones. Each case expects the lower index. The macroblock boundary is the other case that is hard to reach: it appears only after 256 accepted pixels, so a full macroblock is streamed, followed by the start of a second one.

// File: rtl/pvq_pkg.sv
package pvq_pkg;
  localparam int PVQ_CH_W = 5;
  localparam int PVQ_PX_W = 3 * PVQ_CH_W;
  localparam int PVQ_ENT_W = PVQ_PX_W + 1;
  localparam int PVQ_DIST_W = 2 * PVQ_CH_W + 2;

  typedef struct packed {
    logic [PVQ_CH_W-1:0] b;
    logic [PVQ_CH_W-1:0] g;
    logic [PVQ_CH_W-1:0] r;
  } pvq_px_t;
endpackage

// File: rtl/pvq_palette.sv
module pvq_palette
  import pvq_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int WORD_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [$clog2(NUM_ENT)-1:0] rd_idx,
  output pvq_px_t                    rd_px
);
  localparam int EPW    = WORD_W / PVQ_ENT_W;
  localparam int NWORDS = NUM_ENT / EPW;
  localparam int WP_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  pvq_px_t          pal_q [NUM_ENT];
  logic [WP_W-1:0]  wp_q, wp_d;
  logic [EPW-1:0]   spare_bits;
  logic             spare_unused;

  always_comb begin
    wp_d = wp_q;
    if (wr_en) wp_d = (wp_q == WP_W'(NWORDS - 1)) ? '0 : wp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    localparam int WSEL = e / EPW;
    localparam int LANE = e % EPW;
    logic hit;
    assign hit = wr_en && (wp_q == WP_W'(WSEL));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pal_q[e] <= '0;
      else if (hit) pal_q[e] <= wr_data[LANE*PVQ_ENT_W +: PVQ_PX_W];
    end
  end

  for (genvar j = 0; j < EPW; j++) begin : g_spare
    assign spare_bits[j] = wr_data[j*PVQ_ENT_W + PVQ_PX_W];
  end
  assign spare_unused = ^spare_bits;

  assign rd_px = pal_q[rd_idx];
endmodule

// File: rtl/pvq_search.sv
module pvq_search
  import pvq_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_valid,
  input  pvq_px_t                    pix_px,
  output logic                       pix_ready,
  output logic [$clog2(NUM_ENT)-1:0] rd_idx,
  input  pvq_px_t                    rd_px,
  output logic                       res_valid,
  output logic [$clog2(NUM_ENT)-1:0] res_idx
);
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int SQ_W  = 2 * PVQ_CH_W;

  function automatic logic [SQ_W-1:0] sq_diff(input logic [PVQ_CH_W-1:0] a,
                                               input logic [PVQ_CH_W-1:0] b);
    logic [PVQ_CH_W-1:0] d;
    d = (a > b) ? (a - b) : (b - a);
    return {{PVQ_CH_W{1'b0}}, d} * {{PVQ_CH_W{1'b0}}, d};
  endfunction

  logic                  busy_q, busy_d;
  logic [IDX_W-1:0]      k_q, k_d, bidx_q, bidx_d, ridx_q, ridx_d;
  logic [PVQ_DIST_W-1:0] best_q, best_d, cand;
  pvq_px_t               px_q, px_d;
  logic                  rv_q, rv_d, take;

  always_comb begin
    cand = PVQ_DIST_W'(sq_diff(px_q.r, rd_px.r))
         + PVQ_DIST_W'(sq_diff(px_q.g, rd_px.g))
         + PVQ_DIST_W'(sq_diff(px_q.b, rd_px.b));
    take   = cand < best_q;
    busy_d = busy_q;
    k_d    = k_q;
    best_d = best_q;
    bidx_d = bidx_q;
    px_d   = px_q;
    ridx_d = ridx_q;
    rv_d   = 1'b0;
    if (!busy_q) begin
      if (pix_valid) begin
        busy_d = 1'b1;
        k_d    = '0;
        best_d = '1;
        bidx_d = '0;
        px_d   = pix_px;
      end
    end else begin
      if (take) begin
        best_d = cand;
        bidx_d = k_q;
      end
      if (k_q == IDX_W'(NUM_ENT - 1)) begin
        busy_d = 1'b0;
        rv_d   = 1'b1;
        ridx_d = take ? k_q : bidx_q;
      end else begin
        k_d = k_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      best_q <= '1;
      bidx_q <= '0;
      px_q   <= '0;
      ridx_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      k_q    <= k_d;
      best_q <= best_d;
      bidx_q <= bidx_d;
      px_q   <= px_d;
      ridx_q <= ridx_d;
      rv_q   <= rv_d;
    end
  end

  assign pix_ready = !busy_q;
  assign rd_idx    = k_q;
  assign res_valid = rv_q;
  assign res_idx   = ridx_q;
endmodule

// File: rtl/pvq_pack.sv
module pvq_pack #(
  parameter int IDX_W   = 4,
  parameter int MB_PIX  = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic [IDX_W-1:0]   res_idx,
  output logic               out_valid,
  output logic [2*IDX_W-1:0] out_byte,
  output logic               out_last
);
  localparam int NBYTES = MB_PIX / 2;
  localparam int BC_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic               odd_q, odd_d, ov_q, ov_d, ol_q, ol_d;
  logic [IDX_W-1:0]   lo_q, lo_d;
  logic [2*IDX_W-1:0] ob_q, ob_d;
  logic [BC_W-1:0]    cnt_q, cnt_d;
  logic               at_end;

  always_comb begin
    at_end = (cnt_q == BC_W'(NBYTES - 1));
    odd_d  = odd_q;
    lo_d   = lo_q;
    ob_d   = ob_q;
    cnt_d  = cnt_q;
    ov_d   = 1'b0;
    ol_d   = 1'b0;
    if (res_valid) begin
      if (!odd_q) begin
        lo_d  = res_idx;
        odd_d = 1'b1;
      end else begin
        odd_d = 1'b0;
        ov_d  = 1'b1;
        ob_d  = {res_idx, lo_q};
        ol_d  = at_end;
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= 1'b0;
      lo_q  <= '0;
      ob_q  <= '0;
      cnt_q <= '0;
      ov_q  <= 1'b0;
      ol_q  <= 1'b0;
    end else begin
      odd_q <= odd_d;
      lo_q  <= lo_d;
      ob_q  <= ob_d;
      cnt_q <= cnt_d;
      ov_q  <= ov_d;
      ol_q  <= ol_d;
    end
  end

  assign out_valid = ov_q;
  assign out_byte  = ob_q;
  assign out_last  = ol_q;
endmodule

// File: rtl/palette_quantizer.sv
module palette_quantizer
  import pvq_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int WORD_W  = 64,
  parameter int MB_ROWS = 16,
  parameter int MB_COLS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tbl_wr_en,
  input  logic [WORD_W-1:0]              tbl_wr_data,
  input  logic                           pix_valid,
  output logic                           pix_ready,
  input  logic [PVQ_PX_W-1:0]            pix_data,
  output logic                           out_valid,
  output logic [2*$clog2(NUM_ENT)-1:0]   out_byte,
  output logic                           out_last
);
  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam int MB_PIX = MB_ROWS * MB_COLS;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] rd_idx, res_idx;
  pvq_px_t          rd_px, px_in;
  logic             res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];
  assign px_in     = pix_data;

  pvq_palette #(.NUM_ENT(NUM_ENT), .WORD_W(WORD_W)) u_pal (
    .clk(clk), .rst_n(rst_int_n), .wr_en(tbl_wr_en), .wr_data(tbl_wr_data),
    .rd_idx(rd_idx), .rd_px(rd_px)
  );

  pvq_search #(.NUM_ENT(NUM_ENT)) u_search (
    .clk(clk), .rst_n(rst_int_n), .pix_valid(pix_valid), .pix_px(px_in),
    .pix_ready(pix_ready), .rd_idx(rd_idx), .rd_px(rd_px),
    .res_valid(res_valid), .res_idx(res_idx)
  );

  pvq_pack #(.IDX_W(IDX_W), .MB_PIX(MB_PIX)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .res_valid(res_valid), .res_idx(res_idx),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
  );
endmodule

// File: rtl/palette_quantizer_chk.sv
module palette_quantizer_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic pix_ready,
  input logic out_valid,
  input logic out_last
);
  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> !pix_ready);

  // R9
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_ready) |=> !pix_ready);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  out_after_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_ready));

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind palette_quantizer palette_quantizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/palette_quantizer_test.sv
module palette_quantizer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en;
  logic [63:0] tbl_wr_data;
  logic        pix_valid;
  logic        pix_ready;
  logic [14:0] pix_data;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_last;

  always #10 clk = ~clk;

  palette_quantizer uut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_data(tbl_wr_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_out = 0;
  bit done = 0;
  logic [7:0]  got_b [0:255];
  logic        got_l [0:255];
  int          got_c [0:255];
  logic [15:0] pal_img [0:15];

  // {pixel0, pixel1, expected byte}; grey palette entry k = level 2k
  localparam logic [37:0] VEC [0:7] = '{
    {15'd0,     15'h7FFF, 8'hF0},
    {15'h7FFF,  15'd0,    8'h0F},
    {15'd7399,  15'd8456, 8'h43},
    {15'd13741, 15'd2114, 8'h16},
    {15'h001F,  15'd21140, 8'hA5},
    {15'h7C00,  15'd1057, 8'h05},
    {15'h03E0,  15'd31710, 8'hF5},
    {15'h2D4A,  15'd9513, 8'h45}
  };

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (out_valid && n_out < 256) begin
      got_b[n_out] = out_byte;
      got_l[n_out] = out_last;
      got_c[n_out] = cyc;
      n_out++;
    end
  end

  function automatic logic [14:0] gray(input int v);
    return 15'(v * 1057);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_valid = 1'b0; tbl_wr_en = 1'b0;
    tbl_wr_data = '0; pix_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_out = 0;
  endtask

  task automatic load_pal();
    for (int w = 0; w < 4; w++) begin
      tbl_wr_data = {pal_img[4*w+3], pal_img[4*w+2], pal_img[4*w+1], pal_img[4*w]};
      tbl_wr_en = 1'b1;
      @(negedge clk);
    end
    tbl_wr_en = 1'b0;
  endtask

  task automatic set_gray_pal();
    for (int k = 0; k < 16; k++) pal_img[k] = {1'b0, gray(2 * k)};
  endtask

  task automatic send_px(input logic [14:0] p, output int acc);
    pix_valid = 1'b1;
    pix_data  = p;
    while (!pix_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic wait_outs(input int n);
    int t = 0;
    while (n_out < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    int nb;
    do_reset();
    // R1 reset state
    chk(pix_ready == 1'b1, "R1 pix_ready", int'(pix_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
    // R1 zero palette: every pixel codes to 0
    send_px(gray(31), acc);
    send_px(15'h001F, acc);
    wait_outs(1);
    chk(n_out == 1 && got_b[0] == 8'h00, "R1 zero palette", int'(got_b[0]), 0);

    // Vector table: R2 R3 R4 R5 R6
    do_reset();
    set_gray_pal();
    load_pal();
    for (int i = 0; i < 8; i++) begin
      send_px(VEC[i][37:23], acc);
      send_px(VEC[i][22:8], acc);
      wait_outs(i + 1);
      chk(got_b[i] == VEC[i][7:0], "R4 R6 vector", int'(got_b[i]), int'(VEC[i][7:0]));
      // R7 latency from accepting the second pixel
      if (i == 0) chk(got_c[0] - acc == 17, "R7 latency", got_c[0] - acc, 17);
    end
    nb = 8;

    // R9: pix_valid ignored while busy
    send_px(gray(4), acc);
    send_px(gray(24), acc);
    chk(pix_ready == 1'b0, "R9 ready low", int'(pix_ready), 0);
    pix_valid = 1'b1;
    pix_data = gray(0);
    repeat (10) @(negedge clk);
    pix_valid = 1'b0;
    wait_outs(nb + 1);
    repeat (40) @(negedge clk);
    chk(n_out == nb + 1, "R9 no extra output", n_out, nb + 1);
    chk(got_b[nb] == 8'hC2, "R9 busy pixel ignored", int'(got_b[nb]), 8'hC2);
    nb++;

    // R5: all entries identical; load also exercises pointer wrap (R2)
    for (int k = 0; k < 16; k++) pal_img[k] = {1'b0, gray(10)};
    load_pal();
    send_px(gray(3), acc);
    send_px(15'h001F, acc);
    wait_outs(nb + 1);
    chk(got_b[nb] == 8'h00, "R5 R2 uniform tie", int'(got_b[nb]), 0);
    nb++;

    // R5: equal entries at 6 and 11
    for (int k = 0; k < 16; k++) pal_img[k] = {1'b0, gray(30)};
    pal_img[6] = {1'b0, gray(8)};
    pal_img[11] = {1'b0, gray(8)};
    load_pal();
    send_px(gray(8), acc);
    send_px(gray(9), acc);
    wait_outs(nb + 1);
    chk(got_b[nb] == 8'h66, "R5 split tie", int'(got_b[nb]), 8'h66);
    nb++;

    // R2: entry 13 (word 3, lane 1) with spare bit set
    for (int k = 0; k < 16; k++) pal_img[k] = 16'h0000;
    pal_img[13] = 16'h801F;
    load_pal();
    send_px(15'h001F, acc);
    send_px(gray(0), acc);
    wait_outs(nb + 1);
    chk(got_b[nb] == 8'h0D, "R2 lane and spare bit", int'(got_b[nb]), 8'h0D);

    // R8: full macroblock, then start of the next
    do_reset();
    set_gray_pal();
    load_pal();
    for (int i = 0; i < 256; i++) send_px(gray((i * 7) % 32), acc);
    wait_outs(128);
    for (int b = 0; b < 128; b++) begin
      logic [7:0] e;
      e = {4'(((2 * b + 1) * 7 % 32) >> 1), 4'(((2 * b) * 7 % 32) >> 1)};
      chk(got_b[b] == e, "R4 R6 macroblock byte", int'(got_b[b]), int'(e));
      chk(got_l[b] == (b == 127), "R8 last flag", int'(got_l[b]), int'(b == 127));
    end
    send_px(gray(2), acc);
    send_px(gray(6), acc);
    wait_outs(129);
    chk(got_l[128] == 1'b0, "R8 count restarts", int'(got_l[128]), 0);
    chk(got_b[128] == 8'h31, "R6 next block byte", int'(got_b[128]), 8'h31);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule